// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves translation misses with no software help. A requester hands it a virtual page number that was not found in the translation cache. The walker works out where that page's entry sits in a single-level table in memory, and issues exactly one memory read for it. It then decodes the returned entry. A valid entry is written into the translation cache through a fill port, and the requester is told to retry. An invalid entry raises a page-fault pulse that carries the page number.

The walker serves one miss at a time. A new miss waits at the request handshake until the current walk ends. The memory read side uses a valid/ready request and a response strobe, so any latency in either phase is tolerated. The table location comes from a base input. The walker samples it when it accepts a miss, so the base acts as the table's base register for the length of the walk.

Top module: `page_walker`

## Requirements
- R1: While reset is asserted and after it is released, `miss_ready` is 1, and `mem_req_valid`, `fill_valid`, `retry`, `fault_valid` and `walk_done` are 0.
- R2: The read address is `tbl_base + miss_vpn * 2` (2-byte entries), modulo 2^16. Both values are sampled in the cycle the miss is accepted, and later changes to `tbl_base` do not affect the walk.
- R3: `mem_req_valid` rises in the cycle after a miss is accepted. It then stays high, with `mem_req_addr` unchanged, until a cycle in which `mem_req_ready` is 1.
- R4: Any number of cycles may pass before `mem_req_ready` or before `mem_rsp_valid`. A `mem_rsp_valid` that arrives while no response is awaited is ignored.
- R5: The entry format is bit 0 = valid and bits 6:1 = physical page number; bits 15:7 are ignored. A valid entry gives a one-cycle `fill_valid` in the cycle after the response, carrying the walked VPN and the decoded PPN. `retry` is high in that same cycle.
- R6: An entry with bit 0 clear gives a one-cycle `fault_valid` in the cycle after the response, with `fault_vpn` equal to the walked VPN. No fill and no retry occur.
- R7: `walk_done` is a one-cycle pulse that coincides exactly with either `fill_valid` or `fault_valid`.
- R8: `miss_ready` is 0 from the cycle after acceptance until the cycle after `walk_done`. A `miss_valid` seen while busy starts no walk and does not change the walk in progress.
- R9: Each walk performs exactly one memory read handshake. `mem_req_valid` is 0 in the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | Walker is idle and takes the miss |
| miss_vpn | input | 8 | Virtual page number that missed |
| tbl_base | input | 16 | Byte address of the page table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 16 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 16 | Returned table entry |
| fill_valid | output | 1 | Write a translation into the cache |
| fill_vpn | output | 8 | VPN of the fill |
| fill_ppn | output | 6 | PPN of the fill |
| retry | output | 1 | Requester should replay the access |
| fault_valid | output | 1 | Page fault pulse |
| fault_vpn | output | 8 | VPN that faulted |
| walk_done | output | 1 | Walk finished this cycle |

## Verification
The hardest situation to reach from the ports is a walk that is disturbed while it waits. In that case the base changes, a second miss is offered, and a stray response strobe arrives while the request is still unaccepted. Each must leave the address, the single read and the final fill untouched. The stimulus holds `mem_req_ready` low for several cycles and injects all three disturbances inside that window. It then delays the response by a further varying count. A separate idle-time strobe covers responses that come when no walk is running. Table wrap is reached with VPN 0xFF and a base near the top of the address space.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    PW_IDLE  = 3'd0,
    PW_REQ   = 3'd1,
    PW_WAIT  = 3'd2,
    PW_FILL  = 3'd3,
    PW_FAULT = 3'd4
  } pw_state_e;

endpackage

// File: rtl/pw_addr_gen.sv
// Forms the byte address of a table entry from base and page number.
module pw_addr_gen #(
  parameter int ADDR_W    = 16,
  parameter int VPN_W     = 8,
  parameter int PTE_BYTES = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] addr
);

  localparam int SHIFT   = $clog2(PTE_BYTES);
  localparam bit IS_POW2 = ((1 << SHIFT) == PTE_BYTES);

  logic [ADDR_W-1:0] vpn_ext;
  logic [ADDR_W-1:0] offset;

  assign vpn_ext = ADDR_W'(vpn);

  generate
    if (IS_POW2) begin : g_shift
      assign offset = vpn_ext << SHIFT;
    end else begin : g_mul
      assign offset = vpn_ext * ADDR_W'(PTE_BYTES);
    end
  endgenerate

  assign addr = base + offset;

endmodule

// File: rtl/pw_pte_decode.sv
// Splits a returned table entry into its valid flag and frame number.
module pw_pte_decode #(
  parameter int DATA_W    = 16,
  parameter int PPN_W     = 6,
  parameter int VALID_POS = 0,
  parameter int PPN_LSB   = 1
) (
  input  logic [DATA_W-1:0] pte,
  output logic              pte_ok,
  output logic [PPN_W-1:0]  pte_ppn
);

  assign pte_ok  = pte[VALID_POS];
  assign pte_ppn = pte[PPN_LSB +: PPN_W];

endmodule

// File: rtl/pw_fsm.sv
// Walk sequencer: one walk at a time, Moore outputs decoded at the top.
module pw_fsm
  import pw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      miss_valid,
  input  logic      req_ready,
  input  logic      rsp_valid,
  input  logic      pte_ok,
  output pw_state_e state,
  output logic      accept,
  output logic      rsp_take
);

  pw_state_e state_q;
  pw_state_e state_d;

  assign state    = state_q;
  assign accept   = (state_q == PW_IDLE) && miss_valid;
  assign rsp_take = (state_q == PW_WAIT) && rsp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PW_IDLE:  if (miss_valid) state_d = PW_REQ;
      PW_REQ:   if (req_ready)  state_d = PW_WAIT;
      PW_WAIT:  if (rsp_valid)  state_d = pte_ok ? PW_FILL : PW_FAULT;
      PW_FILL:  state_d = PW_IDLE;
      PW_FAULT: state_d = PW_IDLE;
      default:  state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int VPN_W     = 8,
  parameter int PPN_W     = 6,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int PTE_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              fill_valid,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic              retry,
  output logic              fault_valid,
  output logic [VPN_W-1:0]  fault_vpn,
  output logic              walk_done
);

  pw_state_e         state;
  logic              accept;
  logic              rsp_take;
  logic              pte_ok;
  logic [PPN_W-1:0]  pte_ppn;
  logic [ADDR_W-1:0] addr_next;

  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PPN_W-1:0]  ppn_q;

  pw_addr_gen #(
    .ADDR_W   (ADDR_W),
    .VPN_W    (VPN_W),
    .PTE_BYTES(PTE_BYTES)
  ) u_addr (
    .base(tbl_base),
    .vpn (miss_vpn),
    .addr(addr_next)
  );

  pw_pte_decode #(
    .DATA_W   (DATA_W),
    .PPN_W    (PPN_W),
    .VALID_POS(0),
    .PPN_LSB  (1)
  ) u_dec (
    .pte    (mem_rsp_data),
    .pte_ok (pte_ok),
    .pte_ppn(pte_ppn)
  );

  pw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_valid(miss_valid),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .pte_ok    (pte_ok),
    .state     (state),
    .accept    (accept),
    .rsp_take  (rsp_take)
  );

  // Miss capture: page number and entry address, enabled on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      vpn_q  <= miss_vpn;
      addr_q <= addr_next;
    end
  end

  // Frame number capture, enabled when the awaited response arrives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppn_q <= '0;
    end else if (rsp_take) begin
      ppn_q <= pte_ppn;
    end
  end

  assign miss_ready    = (state == PW_IDLE);
  assign mem_req_valid = (state == PW_REQ);
  assign mem_req_addr  = addr_q;
  assign fill_valid    = (state == PW_FILL);
  assign retry         = (state == PW_FILL);
  assign fill_vpn      = vpn_q;
  assign fill_ppn      = ppn_q;
  assign fault_valid   = (state == PW_FAULT);
  assign fault_vpn     = vpn_q;
  assign walk_done     = (state == PW_FILL) || (state == PW_FAULT);

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int VPN_W     = 8,
  parameter int PPN_W     = 6,
  parameter int ADDR_W    = 16,
  parameter int PTE_BYTES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [VPN_W-1:0]  miss_vpn,
  input logic [ADDR_W-1:0] tbl_base,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              fill_valid,
  input logic              retry,
  input logic              fault_valid,
  input logic              walk_done
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (miss_ready && !mem_req_valid && !fill_valid
                                    && !fault_valid && !walk_done && !retry);
    end
  end

  assert_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=>
      (mem_req_addr == ADDR_W'($past(tbl_base) + ADDR_W'($past(miss_vpn)) * ADDR_W'(PTE_BYTES))));

  assert_req_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> mem_req_valid);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fill_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);

  assert_retry_with_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry == fill_valid);

  assert_no_fill_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault_valid));

  assert_done_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done == (fill_valid || fault_valid));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || walk_done) |-> !miss_ready);

  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> miss_ready);

  assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

bind page_walker pw_checker #(
  .VPN_W    (VPN_W),
  .PPN_W    (PPN_W),
  .ADDR_W   (ADDR_W),
  .PTE_BYTES(PTE_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_valid   (miss_valid),
  .miss_ready   (miss_ready),
  .miss_vpn     (miss_vpn),
  .tbl_base     (tbl_base),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .fill_valid   (fill_valid),
  .retry        (retry),
  .fault_valid  (fault_valid),
  .walk_done    (walk_done)
);

// File: tb/sim_page_walker.sv
`timescale 1ns/1ps
module sim_page_walker;

  logic        clk;
  logic        rst_n;
  logic        miss_valid;
  logic        miss_ready;
  logic [7:0]  miss_vpn;
  logic [15:0] tbl_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        fill_valid;
  logic [7:0]  fill_vpn;
  logic [5:0]  fill_ppn;
  logic        retry;
  logic        fault_valid;
  logic [7:0]  fault_vpn;
  logic        walk_done;

  int n_checks = 0;
  int n_fail   = 0;
  int n_reads  = 0;
  int cycles   = 0;
  bit finished = 0;

  page_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vpn(miss_vpn),
    .tbl_base(tbl_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .retry(retry),
    .fault_valid(fault_valid), .fault_vpn(fault_vpn), .walk_done(walk_done)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && mem_req_valid && mem_req_ready) n_reads <= n_reads + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Table contents defined by the bench: VPN 0 -> PPN 0x28 valid, VPN 1 invalid.
  function automatic logic [15:0] pte_of(input logic [7:0] vpn);
    logic [5:0] ppn;
    logic       v;
    if (vpn == 8'h00) begin
      ppn = 6'h28; v = 1'b1;
    end else begin
      ppn = 6'((vpn * 5 + 3) & 8'h3f);
      v   = ((vpn % 3) != 1);
    end
    return {9'h1A5, ppn, v};
  endfunction

  task automatic do_walk(input logic [7:0] vpn, input logic [15:0] base,
                         input int rdly, input int wdly, input bit poke);
    logic [15:0] exp_addr;
    logic [15:0] pte;
    int          r0;
    exp_addr = base + {7'b0, vpn, 1'b0};
    pte      = pte_of(vpn);
    @(negedge clk);
    chk(miss_ready == 1'b1, "R8 ready when idle", miss_ready, 1);
    tbl_base   = base;
    miss_vpn   = vpn;
    miss_valid = 1'b1;
    r0 = n_reads;
    @(negedge clk);
    miss_valid = 1'b0;
    tbl_base   = ~base;
    chk(mem_req_valid == 1'b1, "R3 request raised", mem_req_valid, 1);
    chk(mem_req_addr == exp_addr, "R2 entry address", mem_req_addr, exp_addr);
    chk(miss_ready == 1'b0, "R8 busy after accept", miss_ready, 0);
    for (int i = 0; i < rdly; i++) begin
      if (poke) begin
        miss_valid    = 1'b1;
        miss_vpn      = vpn ^ 8'h55;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = {9'h0, ~pte[6:1], 1'b1};
      end
      @(negedge clk);
      chk(mem_req_valid == 1'b1, "R3 request held", mem_req_valid, 1);
      chk(mem_req_addr == exp_addr, "R3 address stable", mem_req_addr, exp_addr);
      chk(miss_ready == 1'b0, "R8 busy while waiting", miss_ready, 0);
    end
    miss_valid    = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid == 1'b0, "R9 request dropped after handshake", mem_req_valid, 0);
    for (int i = 0; i < wdly; i++) begin
      @(negedge clk);
      chk(!fill_valid && !fault_valid, "R4 no result before response", {fill_valid, fault_valid}, 0);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    if (pte[0]) begin
      chk(fill_valid == 1'b1, "R5 fill pulse", fill_valid, 1);
      chk(retry == 1'b1, "R5 retry with fill", retry, 1);
      chk(fill_vpn == vpn, "R5 fill vpn", fill_vpn, vpn);
      chk(fill_ppn == pte[6:1], "R5 fill ppn", fill_ppn, pte[6:1]);
      chk(fault_valid == 1'b0, "R5 no fault on valid entry", fault_valid, 0);
    end else begin
      chk(fault_valid == 1'b1, "R6 fault pulse", fault_valid, 1);
      chk(fault_vpn == vpn, "R6 fault vpn", fault_vpn, vpn);
      chk(!fill_valid && !retry, "R6 no fill on fault", {fill_valid, retry}, 0);
    end
    chk(walk_done == 1'b1, "R7 done with result", walk_done, 1);
    @(negedge clk);
    chk(!walk_done && !fill_valid && !fault_valid, "R7 single-cycle done",
        {walk_done, fill_valid, fault_valid}, 0);
    chk(miss_ready == 1'b1, "R8 idle after done", miss_ready, 1);
    chk(n_reads - r0 == 1, "R9 exactly one read", n_reads - r0, 1);
  endtask

  task automatic t_reset;
    chk(miss_ready && !mem_req_valid && !fill_valid && !fault_valid && !walk_done && !retry,
        "R1 state in reset", {miss_ready, mem_req_valid, fill_valid, fault_valid, walk_done}, 5'b10000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready && !mem_req_valid && !fill_valid && !fault_valid && !walk_done && !retry,
        "R1 state after reset", {miss_ready, mem_req_valid, fill_valid, fault_valid, walk_done}, 5'b10000);
  endtask

  task automatic t_stray_response;
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 16'h0051;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(!fill_valid && !fault_valid && !walk_done, "R4 idle response ignored",
        {fill_valid, fault_valid, walk_done}, 0);
    @(negedge clk);
    chk(miss_ready == 1'b1 && !mem_req_valid, "R4 still idle", {miss_ready, mem_req_valid}, 2'b10);
  endtask

  initial begin
    while (!finished && cycles < 100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_vpn = '0; tbl_base = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (2) @(negedge clk);
    t_reset();
    do_walk(8'h00, 16'h4000, 0, 0, 1'b0);  // valid, zero latency
    do_walk(8'h01, 16'h4000, 2, 3, 1'b0);  // invalid entry
    do_walk(8'h02, 16'h1234, 4, 1, 1'b1);  // disturbed while request waits
    do_walk(8'h04, 16'h0010, 1, 7, 1'b1);  // fault with disturbance
    do_walk(8'hFF, 16'hFF02, 3, 2, 1'b0);  // address wraps
    t_stray_response();
    do_walk(8'h09, 16'h2000, 0, 12, 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule